// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction Decode

This block is the serial test port of a chip. A test controller drives it through four wires (test clock, mode select, serial data in, asynchronous reset) and reads serial data back on one output. A sixteen-state controller follows the mode-select line on each rising test-clock edge. In its instruction path it loads a 5-bit instruction. In its data path it moves bits through whichever data register the current instruction selects. There are two data registers: a 1-bit pass-through stage and a 32-bit identification register.

Three opcodes are decoded. IDENT (00110) selects the identification register. PASS (11111) selects the 1-bit stage. FLOAT (00101) also selects the 1-bit stage, and it additionally asserts a chip-wide output-disable that puts every functional output into an inactive drive state. Two outputs report the decoded instruction to the rest of the chip. `sys_mode` is high when the boundary cells run in normal system mode. `out_hiz` is the output-disable. Serial data leaves on the falling test-clock edge, together with an output-enable that is active only in the two shift states.

Top module: `scan_tap_port`

## Requirements
- R1: The controller has sixteen states and moves between them on each rising `tck` edge, following `tms` in the standard test-port order. From any state, five consecutive rising edges with `tms` high reach Test-Logic-Reset. On the next rising edge in that state, IDENT is reloaded as the active instruction.
- R2: While `trst_n` is low, the controller is forced into Test-Logic-Reset without a clock edge. The active instruction becomes IDENT, so `out_hiz` is 0 and `sys_mode` is 1, and `tdo_oe` is 0.
- R3: In Capture-IR, the instruction shift stage loads 00001. Shifting runs LSB first out of `tdo`, with `tdi` entering at the MSB, so the bits read are 1,0,0,0,0.
- R4: A shifted opcode becomes the active instruction only on the rising edge that leaves Update-IR. While the opcode is being shifted, `out_hiz` and `sys_mode` keep their previous values.
- R5: IDENT (00110) places the 32-bit identification register between `tdi` and `tdo`. Capture-DR loads `ID_VALUE`, whose bit 0 is 1. Shift-DR sends that value out LSB first while `tdi` bits enter at the MSB.
- R6: PASS (11111) places the 1-bit stage between `tdi` and `tdo`. Capture-DR loads it with 0, so the first bit read is 0. Each later bit read equals the `tdi` bit shifted one clock earlier. `sys_mode` is 1 and `out_hiz` is 0.
- R7: FLOAT (00101) uses the same 1-bit path and the same timing as PASS. It drives `out_hiz` to 1 and `sys_mode` to 0.
- R8: Any other opcode behaves as PASS: 1-bit path, `sys_mode` 1, `out_hiz` 0.
- R9: `tdo` and `tdo_oe` change only on the falling `tck` edge. `tdo_oe` is 1 only in the half cycle after a falling edge at which the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising `tck` edge |
| tdi | input | 1 | Serial data in, sampled on the rising `tck` edge |
| tdo | output | 1 | Serial data out, updated on the falling `tck` edge |
| tdo_oe | output | 1 | Drive enable for `tdo`, high only while shifting |
| sys_mode | output | 1 | Boundary cells run in normal system mode |
| out_hiz | output | 1 | Forces all functional outputs to an inactive drive state |

## Verification
The bench shifts bits and compares every `tdo` bit with a queue of expected bits. This catches a capture value of 1 in the 1-bit stage, which would make the first bit wrong, and an MSB-first identification shift, whose first bit would be 0 instead of 1. It reads `out_hiz` between the end of shifting FLOAT and Update-IR, which exposes a design that decodes the shift stage instead of the latched instruction. It loads an undefined opcode, which catches a decoder that routes unknown codes to the identification register. It also samples `tdo` between the rising and the falling edge, which catches output logic clocked on the wrong edge. Finally, the TMS-high escape and an asynchronous reset taken during FLOAT must both clear the output-disable.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

   typedef enum logic [3:0] {
      ST_RESET, ST_IDLE,
      ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
      ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
   } tap_state_e;

   function automatic tap_state_e tap_next(input tap_state_e st, input logic tms);
      tap_state_e nx;
      unique case (st)
         ST_RESET:    nx = tms ? ST_RESET    : ST_IDLE;
         ST_IDLE:     nx = tms ? ST_DR_SEL   : ST_IDLE;
         ST_DR_SEL:   nx = tms ? ST_IR_SEL   : ST_DR_CAP;
         ST_DR_CAP:   nx = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
         ST_DR_SHIFT: nx = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
         ST_DR_EXIT1: nx = tms ? ST_DR_UPD   : ST_DR_PAUSE;
         ST_DR_PAUSE: nx = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
         ST_DR_EXIT2: nx = tms ? ST_DR_UPD   : ST_DR_SHIFT;
         ST_DR_UPD:   nx = tms ? ST_DR_SEL   : ST_IDLE;
         ST_IR_SEL:   nx = tms ? ST_RESET    : ST_IR_CAP;
         ST_IR_CAP:   nx = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
         ST_IR_SHIFT: nx = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
         ST_IR_EXIT1: nx = tms ? ST_IR_UPD   : ST_IR_PAUSE;
         ST_IR_PAUSE: nx = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
         ST_IR_EXIT2: nx = tms ? ST_IR_UPD   : ST_IR_SHIFT;
         ST_IR_UPD:   nx = tms ? ST_DR_SEL   : ST_IDLE;
         default:     nx = ST_RESET;
      endcase
      return nx;
   endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
   import scan_tap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_e state
);

   tap_state_e state_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state_q <= ST_RESET;
      else         state_q <= tap_next(state_q, tms);
   end

   assign state = state_q;

endmodule

// File: rtl/scan_tap_ireg.sv
module scan_tap_ireg
   import scan_tap_pkg::*;
#(
   parameter int unsigned IR_W      = 5,
   parameter logic [IR_W-1:0] OP_FLOAT = 5'b00101,
   parameter logic [IR_W-1:0] OP_IDENT = 5'b00110,
   parameter logic [IR_W-1:0] OP_PASS  = 5'b11111
) (
   input  logic            tck,
   input  logic            trst_n,
   input  tap_state_e      state,
   input  logic            tdi,
   output logic            ir_sdo,
   output logic [IR_W-1:0] ir_shift,
   output logic [IR_W-1:0] ir_active,
   output logic            sel_ident,
   output logic            hiz
);

   localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-1){1'b0}}, 1'b1};

   logic [IR_W-1:0] shift_q;
   logic [IR_W-1:0] active_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         shift_q  <= CAP_PAT;
         active_q <= OP_IDENT;
      end else begin
         unique case (state)
            ST_RESET:    active_q <= OP_IDENT;
            ST_IR_CAP:   shift_q  <= CAP_PAT;
            ST_IR_SHIFT: shift_q  <= {tdi, shift_q[IR_W-1:1]};
            ST_IR_UPD:   active_q <= shift_q;
            default:     ;
         endcase
      end
   end

   // Unlisted opcodes fall through to the pass-through stage
   always_comb begin
      sel_ident = 1'b0;
      hiz       = 1'b0;
      if (active_q == OP_IDENT)      sel_ident = 1'b1;
      else if (active_q == OP_FLOAT) hiz       = 1'b1;
      else if (active_q == OP_PASS)  hiz       = 1'b0;
   end

   assign ir_sdo    = shift_q[0];
   assign ir_shift  = shift_q;
   assign ir_active = active_q;

endmodule

// File: rtl/scan_tap_dreg.sv
module scan_tap_dreg
   import scan_tap_pkg::*;
#(
   parameter int unsigned ID_W = 32,
   parameter logic [ID_W-1:0] ID_VALUE = 32'h4A7C_305B
) (
   input  logic       tck,
   input  logic       trst_n,
   input  tap_state_e state,
   input  logic       tdi,
   input  logic       sel_ident,
   output logic       pass_q,
   output logic       dr_sdo
);

   logic [ID_W-1:0] id_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         pass_q <= 1'b0;
      end else if (state == ST_DR_CAP) begin
         pass_q <= 1'b0;
      end else if (state == ST_DR_SHIFT && !sel_ident) begin
         pass_q <= tdi;
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         id_q <= ID_VALUE;
      end else if (sel_ident) begin
         if (state == ST_DR_CAP)        id_q <= ID_VALUE;
         else if (state == ST_DR_SHIFT) id_q <= {tdi, id_q[ID_W-1:1]};
      end
   end

   assign dr_sdo = sel_ident ? id_q[0] : pass_q;

endmodule

// File: rtl/scan_tap_port.sv
module scan_tap_port
   import scan_tap_pkg::*;
#(
   parameter int unsigned IR_W = 5,
   parameter int unsigned ID_W = 32,
   parameter logic [ID_W-1:0] ID_VALUE = 32'h4A7C_305B,
   parameter logic [IR_W-1:0] OP_FLOAT = 5'b00101,
   parameter logic [IR_W-1:0] OP_IDENT = 5'b00110,
   parameter logic [IR_W-1:0] OP_PASS  = 5'b11111,
   parameter bit TDO_ON_FALL = 1'b1
) (
   input  logic tck,
   input  logic trst_n,
   input  logic tms,
   input  logic tdi,
   output logic tdo,
   output logic tdo_oe,
   output logic sys_mode,
   output logic out_hiz
);

   if (IR_W < 2) begin : g_bad_irw
      $error("IR_W must be at least 2");
   end
   if (ID_W < 2) begin : g_bad_idw
      $error("ID_W must be at least 2");
   end
   if (ID_VALUE[0] != 1'b1) begin : g_bad_id
      $error("ID_VALUE bit 0 must be 1");
   end
   if (OP_FLOAT == OP_IDENT || OP_FLOAT == OP_PASS || OP_IDENT == OP_PASS) begin : g_bad_op
      $error("opcodes must be distinct");
   end

   tap_state_e      state_q;
   logic            ir_sdo, dr_sdo, sel_ident, hiz, pass_q;
   logic [IR_W-1:0] ir_shift, ir_active;
   logic            sdo_next, oe_next;

   scan_tap_fsm u_fsm (
      .tck(tck), .trst_n(trst_n), .tms(tms), .state(state_q)
   );

   scan_tap_ireg #(
      .IR_W(IR_W), .OP_FLOAT(OP_FLOAT), .OP_IDENT(OP_IDENT), .OP_PASS(OP_PASS)
   ) u_ireg (
      .tck(tck), .trst_n(trst_n), .state(state_q), .tdi(tdi),
      .ir_sdo(ir_sdo), .ir_shift(ir_shift), .ir_active(ir_active),
      .sel_ident(sel_ident), .hiz(hiz)
   );

   scan_tap_dreg #(
      .ID_W(ID_W), .ID_VALUE(ID_VALUE)
   ) u_dreg (
      .tck(tck), .trst_n(trst_n), .state(state_q), .tdi(tdi),
      .sel_ident(sel_ident), .pass_q(pass_q), .dr_sdo(dr_sdo)
   );

   assign sdo_next = (state_q == ST_IR_SHIFT) ? ir_sdo : dr_sdo;
   assign oe_next  = (state_q == ST_IR_SHIFT) || (state_q == ST_DR_SHIFT);

   if (TDO_ON_FALL) begin : g_out_fall
      always_ff @(negedge tck or negedge trst_n) begin
         if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
         end else begin
            tdo    <= sdo_next;
            tdo_oe <= oe_next;
         end
      end
   end else begin : g_out_rise
      always_ff @(posedge tck or negedge trst_n) begin
         if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
         end else begin
            tdo    <= sdo_next;
            tdo_oe <= oe_next;
         end
      end
   end

   assign out_hiz  = hiz;
   assign sys_mode = ~hiz;

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
   import scan_tap_pkg::*;
#(
   parameter int unsigned IR_W = 5
) (
   input logic            tck,
   input logic            trst_n,
   input logic            tms,
   input tap_state_e      state,
   input logic [IR_W-1:0] ir_shift,
   input logic [IR_W-1:0] ir_active,
   input logic            pass_q,
   input logic            tdo_oe,
   input logic            sys_mode,
   input logic            out_hiz
);

   logic [2:0] tms_run;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)           tms_run <= '0;
      else if (!tms)         tms_run <= '0;
      else if (tms_run != 3'd7) tms_run <= tms_run + 3'd1;
   end

   // R1: five TMS-high edges land in Test-Logic-Reset
   p_tms_escape_r1: assert property (@(posedge tck) disable iff (!trst_n)
      (tms_run >= 3'd5) |-> (state == ST_RESET));

   // R3: Capture-IR loads the fixed pattern
   p_ir_capture_r3: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_IR_CAP) |=> (ir_shift == {{(IR_W-1){1'b0}}, 1'b1}));

   // R4: active instruction only moves at Update-IR or in reset
   p_ir_hold_r4: assert property (@(posedge tck) disable iff (!trst_n)
      (state != ST_IR_UPD && state != ST_RESET) |=> $stable(ir_active));

   // R6: Capture-DR clears the pass-through stage
   p_pass_capture_r6: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_DR_CAP) |=> (pass_q == 1'b0));

   // R7: output-disable and normal mode never coexist
   p_float_mode_r7: assert property (@(posedge tck) disable iff (!trst_n)
      !(out_hiz && sys_mode));

   // R9: output enable only while shifting
   p_oe_shift_r9: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_oe |-> (state == ST_IR_SHIFT || state == ST_DR_SHIFT));

endmodule

bind scan_tap_port scan_tap_chk #(.IR_W(IR_W)) u_chk (
   .tck(tck), .trst_n(trst_n), .tms(tms), .state(state_q),
   .ir_shift(ir_shift), .ir_active(ir_active), .pass_q(pass_q),
   .tdo_oe(tdo_oe), .sys_mode(sys_mode), .out_hiz(out_hiz)
);

// File: tb/test_scan_tap_port.sv
`timescale 1ns/1ps
module test_scan_tap_port;

   localparam int CLK_PERIOD = 10;
   localparam int HALF = CLK_PERIOD / 2;
   localparam logic [31:0] ID_VAL = 32'h4A7C_305B;
   localparam logic [4:0] C_FLOAT = 5'b00101;
   localparam logic [4:0] C_IDENT = 5'b00110;
   localparam logic [4:0] C_PASS  = 5'b11111;

   logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
   logic tdo, tdo_oe, sys_mode, out_hiz;

   int n_tests = 0;
   int n_fail  = 0;
   logic exp_q[$];
   string tag_q[$];
   logic mon_on = 1'b0;

   scan_tap_port #(.ID_VALUE(ID_VAL)) i_scan_tap_port (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
      .tdo(tdo), .tdo_oe(tdo_oe), .sys_mode(sys_mode), .out_hiz(out_hiz)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   // monitor: pop the expected bit at each rising edge inside a shift state
   always @(posedge tck) begin
      if (mon_on) begin
         logic e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check({t, " tdo"}, tdo, e);
         check("R9 tdo_oe in shift", tdo_oe, 1'b1);
      end
   end

   task automatic step(input logic m, input logic d);
      tms = m; tdi = d;
      #HALF tck = 1'b1;
      #HALF tck = 1'b0;
      #1;
   endtask

   // from Run-Test/Idle, load an opcode; expected hiz before and after update
   task automatic load_ir(input logic [4:0] op, input logic hiz_after);
      logic hiz_before;
      hiz_before = out_hiz;
      step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < 5; i++) begin
         exp_q.push_back(i == 0);  // R3 pattern 00001 LSB first
         tag_q.push_back("R3");
         mon_on = 1'b1;
         step(i == 4, op[i]);
      end
      mon_on = 1'b0;
      check("R4 hiz held before update", out_hiz, hiz_before);
      step(1, 0);
      check("R4 hiz held in update", out_hiz, hiz_before);
      step(0, 0);
      check("R4 hiz after update", out_hiz, hiz_after);
      check("R4 sys_mode after update", sys_mode, ~hiz_after);
   endtask

   // from Run-Test/Idle, shift n data bits; use_id picks the expectation
   task automatic shift_dr(input int n, input logic [31:0] d, input logic use_id, input string tag);
      step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < n; i++) begin
         if (use_id) exp_q.push_back(ID_VAL[i]);
         else        exp_q.push_back(i == 0 ? 1'b0 : d[i-1]);
         tag_q.push_back(tag);
         mon_on = 1'b1;
         step(i == n - 1, d[i]);
      end
      mon_on = 1'b0;
      check("R9 tdo_oe off after shift", tdo_oe, 1'b0);
      step(1, 0); step(0, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #3;
      check("R2 tdo_oe in reset", tdo_oe, 1'b0);
      check("R2 out_hiz in reset", out_hiz, 1'b0);
      check("R2 sys_mode in reset", sys_mode, 1'b1);
      trst_n = 1'b1;
      step(0, 0);
      check("R9 tdo_oe idle", tdo_oe, 1'b0);

      // R5 default instruction after reset is IDENT
      check("R5 id lsb", ID_VAL[0], 1'b1);
      shift_dr(32, 32'hFFFF_0000, 1'b1, "R5");

      // R6 pass-through
      load_ir(C_PASS, 1'b0);
      shift_dr(9, 32'h0000_01B5, 1'b0, "R6");
      check("R6 sys_mode", sys_mode, 1'b1);

      // R9 output changes on falling edge only
      step(1, 0); step(0, 0); step(0, 0);   // now in Shift-DR, tdo = 0
      tms = 1'b0; tdi = 1'b1;
      #HALF tck = 1'b1;
      #1 check("R9 tdo not moved at rise", tdo, 1'b0);
      #(HALF - 1) tck = 1'b0;
      #1 check("R9 tdo moved at fall", tdo, 1'b1);
      step(1, 0); step(1, 0); step(0, 0);

      // R7 float
      load_ir(C_FLOAT, 1'b1);
      check("R7 sys_mode low", sys_mode, 1'b0);
      shift_dr(7, 32'h0000_004D, 1'b0, "R7");
      check("R7 out_hiz kept", out_hiz, 1'b1);

      // R8 undefined opcode
      load_ir(5'b01010, 1'b0);
      check("R8 sys_mode", sys_mode, 1'b1);
      shift_dr(6, 32'h0000_002B, 1'b0, "R8");

      // R1 TMS escape from float
      load_ir(C_FLOAT, 1'b1);
      step(1, 0); step(0, 0); step(0, 0);   // into Shift-DR
      for (int i = 0; i < 5; i++) step(1, 0);
      check("R1 tdo_oe after escape", tdo_oe, 1'b0);
      step(1, 0);
      check("R1 out_hiz cleared", out_hiz, 1'b0);
      step(0, 0);
      shift_dr(32, 32'h1234_5678, 1'b1, "R1");

      // R2 asynchronous reset during float
      load_ir(C_FLOAT, 1'b1);
      #2 trst_n = 1'b0;
      #1 check("R2 async out_hiz", out_hiz, 1'b0);
      check("R2 async sys_mode", sys_mode, 1'b1);
      #2 trst_n = 1'b1;
      step(0, 0);
      shift_dr(32, 32'h0, 1'b1, "R2");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule